// File: doc/BRIEF.md
# Store Redo Log Controller

This block keeps a program-ordered log of every store that issues while a long-latency cache miss is outstanding. The log sits next to a small first-level store queue. A store that does not depend on the miss is logged and also written to the data cache at once as a speculative update, so that later loads can take their data from the cache. A store that depends on the miss is logged without data and frees its first-level queue slot straight away. Its data arrives later through a fill port, addressed by the log position that was returned when the store was accepted. The log is a plain indexed storage FIFO. It has no address comparators, and no load ever searches it.

When the miss returns, the controller sends the cache a one-cycle request to flash-invalidate every speculative store update. It then waits for the cache to acknowledge. After that it replays the log oldest-first, writing each entry's address and data back into the cache. A store is re-applied, not re-executed. The controller moves through five named states. IDLE goes to SHADOW when a miss becomes pending. SHADOW goes to PURGE_REQ when the miss clears. PURGE_REQ always goes to PURGE_WAIT one cycle later. PURGE_WAIT goes to REPLAY when the acknowledge is seen. REPLAY goes back to IDLE once the log is empty.

The default log depth is 512 entries. The depth must be a power of two.

Top module: `srlog_ctrl`

## Requirements
- R1: `st_ready` is high only in SHADOW while the log is not full. A store is taken when `st_valid` and `st_ready` are both high in the same cycle. `st_idx` gives that store's log slot, and consecutive stores get consecutive slots modulo DEPTH. `st_ready` and `drain_valid` are never high together.
- R2: In the cycle a store is taken with `st_dep`=0, `spec_wr_valid` is high and carries that store's address and data. In the cycle a store is taken with `st_dep`=1, `spec_wr_valid` is low and `l1q_release` is high.
- R3: `log_full` is high while DEPTH entries are held, and `st_ready` is low at that time. A store offered while the log is full causes no speculative write and is never replayed.
- R4: On the first cycle after `miss_pend` is sampled low in SHADOW, `inval_req` is high for exactly one cycle.
- R5: `drain_valid` stays low from the invalidate request until `inval_ack` is sampled high. It may rise at the earliest on the cycle after that.
- R6: Replay writes the entries oldest-first. Each write carries the recorded address. The data is the store data for an independent entry, or the first filled data for a dependent entry.
- R7: `drain_valid` is low while the oldest entry is a dependent entry that has not been filled. A fill sampled at an edge lets that entry drain from the next cycle on.
- R8: A fill to an entry that was not logged as dependent, or to an entry that has already been filled, has no effect.
- R9: An entry leaves the log only in a cycle where `drain_valid` and `drain_grant` are both high. While the write is not granted, `drain_valid`, `drain_addr` and `drain_data` hold their values.
- R10: Once the last entry has drained, the controller returns to IDLE on the following edge. Stores offered during replay are ignored.
- R11: After reset, the controller is in IDLE with `st_ready`, `inval_req`, `drain_valid` and `log_full` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_pend | input | 1 | A long-latency miss is outstanding |
| st_valid | input | 1 | Store offered for logging |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data (ignored when dependent) |
| st_dep | input | 1 | Store depends on the miss |
| st_ready | output | 1 | Log accepts a store this cycle |
| st_idx | output | $clog2(DEPTH) | Log slot given to the accepted store |
| spec_wr_valid | output | 1 | Speculative cache write for an independent store |
| spec_wr_addr | output | ADDR_W | Speculative write address |
| spec_wr_data | output | DATA_W | Speculative write data |
| l1q_release | output | 1 | First-level queue slot freed by a dependent store |
| fill_valid | input | 1 | Late data for a dependent entry |
| fill_idx | input | $clog2(DEPTH) | Log slot being filled |
| fill_data | input | DATA_W | Fill data |
| inval_req | output | 1 | One-cycle flash-invalidate request to the cache |
| inval_ack | input | 1 | Cache has discarded speculative updates |
| drain_valid | output | 1 | Replay write offered to the cache |
| drain_addr | output | ADDR_W | Replay write address |
| drain_data | output | DATA_W | Replay write data |
| drain_grant | input | 1 | Cache accepts the replay write |
| log_full | output | 1 | Log holds DEPTH entries |

## Verification
The store-side outputs (`st_ready`, `st_idx`, `spec_wr_*` and `l1q_release`) respond in the same cycle. The bench therefore reads them shortly after it drives a store, before the next rising edge. `inval_req` rises one edge after the miss clears, and the first replay write can appear one edge after the acknowledge. A fill becomes visible at the log head one edge after it is sampled. The bench keeps a model of which entries are ready and updates it only after the edge that writes each fill. It runs a sweep over log occupancy, dependency patterns, early and late fills, and several grant patterns. Every check samples at the falling edge that follows the register feeding the checked output.

// File: rtl/srlog_pkg.sv
package srlog_pkg;

    typedef enum logic [2:0] {
        S_IDLE       = 3'd0,
        S_SHADOW     = 3'd1,
        S_PURGE_REQ  = 3'd2,
        S_PURGE_WAIT = 3'd3,
        S_REPLAY     = 3'd4
    } srlog_state_e;

endpackage

// File: rtl/srlog_ptrs.sv
module srlog_ptrs #(
    parameter int DEPTH = 512,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] head_idx,
    output logic [PTR_W-1:0] tail_idx,
    output logic             full,
    output logic             empty
);

    // one extra wrap bit separates full from empty
    logic [PTR_W:0] head_q;
    logic [PTR_W:0] tail_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (push) tail_q <= tail_q + 1'b1;
            if (pop)  head_q <= head_q + 1'b1;
        end
    end

    assign head_idx = head_q[PTR_W-1:0];
    assign tail_idx = tail_q[PTR_W-1:0];
    assign empty    = (head_q == tail_q);
    assign full     = (head_q[PTR_W] != tail_q[PTR_W]) &&
                      (head_q[PTR_W-1:0] == tail_q[PTR_W-1:0]);

endmodule

// File: rtl/srlog_store.sv
module srlog_store #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int DEPTH  = 512,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    // allocation at the tail
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_dep,
    // late data for dependent entries
    input  logic              fill_en,
    input  logic [PTR_W-1:0]  fill_idx,
    input  logic [DATA_W-1:0] fill_data,
    // head read and retire
    input  logic [PTR_W-1:0]  rd_idx,
    input  logic              rd_pop,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ready
);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  dv_q;
    logic [DEPTH-1:0]  dep_q;
    logic              fill_take;

    // a fill lands only on a dependent slot still waiting for data
    assign fill_take = fill_en && dep_q[fill_idx] && !dv_q[fill_idx];

    always_ff @(posedge clk) begin
        if (fill_take) data_q[fill_idx] <= fill_data;
        if (wr_en) begin
            addr_q[wr_idx] <= wr_addr;
            data_q[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q  <= '0;
            dep_q <= '0;
        end else begin
            if (fill_take) dv_q[fill_idx] <= 1'b1;
            if (rd_pop)    dep_q[rd_idx]  <= 1'b0;
            if (wr_en) begin
                dep_q[wr_idx] <= wr_dep;
                dv_q[wr_idx]  <= !wr_dep;
            end
        end
    end

    assign rd_addr  = addr_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
    assign rd_ready = dv_q[rd_idx];

endmodule

// File: rtl/srlog_fsm.sv
module srlog_fsm
    import srlog_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         miss_pend,
    input  logic         inval_ack,
    input  logic         log_empty,
    output srlog_state_e state,
    output logic         shadow,
    output logic         purge_req,
    output logic         replay
);

    srlog_state_e state_q;
    srlog_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (miss_pend)  state_d = S_SHADOW;
            S_SHADOW:     if (!miss_pend) state_d = S_PURGE_REQ;
            S_PURGE_REQ:                  state_d = S_PURGE_WAIT;
            S_PURGE_WAIT: if (inval_ack)  state_d = S_REPLAY;
            S_REPLAY:     if (log_empty)  state_d = S_IDLE;
            default:                      state_d = S_IDLE;
        endcase
    end

    always_comb begin
        shadow    = 1'b0;
        purge_req = 1'b0;
        replay    = 1'b0;
        unique case (state_q)
            S_IDLE:       ;
            S_SHADOW:     shadow    = 1'b1;
            S_PURGE_REQ:  purge_req = 1'b1;
            S_PURGE_WAIT: ;
            S_REPLAY:     replay    = 1'b1;
            default:      ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/srlog_ctrl.sv
module srlog_ctrl #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int DEPTH  = 512,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_pend,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              st_dep,
    output logic              st_ready,
    output logic [PTR_W-1:0]  st_idx,
    output logic              spec_wr_valid,
    output logic [ADDR_W-1:0] spec_wr_addr,
    output logic [DATA_W-1:0] spec_wr_data,
    output logic              l1q_release,
    input  logic              fill_valid,
    input  logic [PTR_W-1:0]  fill_idx,
    input  logic [DATA_W-1:0] fill_data,
    output logic              inval_req,
    input  logic              inval_ack,
    output logic              drain_valid,
    output logic [ADDR_W-1:0] drain_addr,
    output logic [DATA_W-1:0] drain_data,
    input  logic              drain_grant,
    output logic              log_full
);

    import srlog_pkg::*;

    srlog_state_e     state;
    logic             shadow;
    logic             replay;
    logic             full;
    logic             empty;
    logic             accept;
    logic             pop;
    logic             head_ready;
    logic [PTR_W-1:0] head_idx;
    logic [PTR_W-1:0] tail_idx;

    srlog_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .miss_pend (miss_pend),
        .inval_ack (inval_ack),
        .log_empty (empty),
        .state     (state),
        .shadow    (shadow),
        .purge_req (inval_req),
        .replay    (replay)
    );

    srlog_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .pop      (pop),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .full     (full),
        .empty    (empty)
    );

    srlog_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept),
        .wr_idx    (tail_idx),
        .wr_addr   (st_addr),
        .wr_data   (st_data),
        .wr_dep    (st_dep),
        .fill_en   (fill_valid),
        .fill_idx  (fill_idx),
        .fill_data (fill_data),
        .rd_idx    (head_idx),
        .rd_pop    (pop),
        .rd_addr   (drain_addr),
        .rd_data   (drain_data),
        .rd_ready  (head_ready)
    );

    // store side: only in the miss shadow, never past capacity
    assign st_ready      = shadow && !full;
    assign accept        = st_valid && st_ready;
    assign st_idx        = tail_idx;
    assign spec_wr_valid = accept && !st_dep;
    assign spec_wr_addr  = st_addr;
    assign spec_wr_data  = st_data;
    assign l1q_release   = accept && st_dep;
    assign log_full      = full;

    // replay side: head must hold data, cache must grant
    assign drain_valid = replay && !empty && head_ready;
    assign pop         = drain_valid && drain_grant;

endmodule

// File: rtl/srlog_ctrl_chk.sv
module srlog_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_ready,
    input logic              spec_wr_valid,
    input logic              l1q_release,
    input logic              inval_req,
    input logic              drain_valid,
    input logic              drain_grant,
    input logic [ADDR_W-1:0] drain_addr,
    input logic [DATA_W-1:0] drain_data,
    input logic              log_full
);

    // R1
    ready_drain_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_ready && drain_valid));

    // R2
    spec_release_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(spec_wr_valid && l1q_release));

    // R3
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_full |-> !st_ready);

    // R4
    inval_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval_req |=> !inval_req);

    // R5
    no_drain_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval_req |-> !drain_valid ##1 !drain_valid);

    // R9
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_valid && !drain_grant) |=>
            (drain_valid && $stable(drain_addr) && $stable(drain_data)));

endmodule

bind srlog_ctrl srlog_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_ready      (st_ready),
    .spec_wr_valid (spec_wr_valid),
    .l1q_release   (l1q_release),
    .inval_req     (inval_req),
    .drain_valid   (drain_valid),
    .drain_grant   (drain_grant),
    .drain_addr    (drain_addr),
    .drain_data    (drain_data),
    .log_full      (log_full)
);

// File: tb/srlog_ctrl_bench.sv
`timescale 1ns/1ps
module srlog_ctrl_bench;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int DP = 8;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_pend = 1'b0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_dep = 1'b0;
    logic          st_ready;
    logic [PW-1:0] st_idx;
    logic          spec_wr_valid;
    logic [AW-1:0] spec_wr_addr;
    logic [DW-1:0] spec_wr_data;
    logic          l1q_release;
    logic          fill_valid = 1'b0;
    logic [PW-1:0] fill_idx = '0;
    logic [DW-1:0] fill_data = '0;
    logic          inval_req;
    logic          inval_ack = 1'b0;
    logic          drain_valid;
    logic [AW-1:0] drain_addr;
    logic [DW-1:0] drain_data;
    logic          drain_grant = 1'b0;
    logic          log_full;

    int checks = 0;
    int errors = 0;
    int base = 0;

    always #2.5 clk = ~clk;

    srlog_ctrl #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP)) u_srlog_ctrl (
        .clk(clk), .rst_n(rst_n), .miss_pend(miss_pend),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_dep(st_dep),
        .st_ready(st_ready), .st_idx(st_idx),
        .spec_wr_valid(spec_wr_valid), .spec_wr_addr(spec_wr_addr),
        .spec_wr_data(spec_wr_data), .l1q_release(l1q_release),
        .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_data(fill_data),
        .inval_req(inval_req), .inval_ack(inval_ack),
        .drain_valid(drain_valid), .drain_addr(drain_addr), .drain_data(drain_data),
        .drain_grant(drain_grant), .log_full(log_full)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit grant_of(input int mode, input int c);
        if (mode == 0) return 1'b1;
        if (mode == 1) return (c % 3) != 2;
        return (c % 2) == 1;
    endfunction

    task automatic run(input int n, input bit late, input int gmode);
        logic [AW-1:0] e_addr [DP];
        logic [DW-1:0] e_data [DP];
        bit            e_dep  [DP];
        bit            e_rdy  [DP];
        string         e_tag  [DP];
        int j, c, kd, ki, fk;
        bit v, g, held;

        kd = -1; ki = -1;
        for (int i = 0; i < n; i++) begin
            e_dep[i]  = ((i * 5 + n + int'(late)) % 3) == 0;
            e_addr[i] = AW'(base * 7 + i * 13 + 1);
            e_data[i] = e_dep[i] ? DW'(16'hA000 ^ (n * 16 + i)) : DW'(16'h1000 + n * 256 + i);
            e_rdy[i]  = !e_dep[i];
            e_tag[i]  = "R6";
            if (e_dep[i] && kd < 0) kd = i;
            if (!e_dep[i] && ki < 0) ki = i;
        end

        @(negedge clk); miss_pend = 1'b1;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            st_valid = 1'b1; st_addr = e_addr[i]; st_dep = e_dep[i];
            st_data = e_dep[i] ? DW'(16'h5555) : e_data[i];
            #1;
            check("R1 ready", st_ready, 1);
            check("R1 idx", st_idx, (base + i) % DP);
            check("R2 spec", spec_wr_valid, !e_dep[i]);
            check("R2 release", l1q_release, e_dep[i]);
            if (!e_dep[i]) begin
                check("R2 addr", spec_wr_addr, e_addr[i]);
                check("R2 data", spec_wr_data, e_data[i]);
            end
            @(negedge clk);
        end
        st_valid = 1'b0;
        #1 check("R3 full", log_full, n == DP);
        if (n == DP) begin
            st_valid = 1'b1; st_dep = 1'b0; st_addr = 8'hEE; st_data = 16'hBEEF;
            #1;
            check("R3 ready", st_ready, 0);
            check("R3 spec", spec_wr_valid, 0);
            @(negedge clk); st_valid = 1'b0;
        end

        if (!late) begin
            for (int k = n - 1; k >= 0; k--) begin
                if (e_dep[k]) begin
                    fill_valid = 1'b1; fill_idx = PW'(base + k); fill_data = e_data[k];
                    @(negedge clk); e_rdy[k] = 1'b1;
                end
            end
            if (kd >= 0) begin
                fill_valid = 1'b1; fill_idx = PW'(base + kd); fill_data = 16'hDEAD;
                e_tag[kd] = "R8";
                @(negedge clk);
            end
            if (ki >= 0) begin
                fill_valid = 1'b1; fill_idx = PW'(base + ki); fill_data = 16'hDEAD;
                e_tag[ki] = "R8";
                @(negedge clk);
            end
            fill_valid = 1'b0;
        end

        miss_pend = 1'b0;
        @(negedge clk); #1 check("R4 req", inval_req, 1);
        @(negedge clk); #1 check("R4 single", inval_req, 0);
        check("R5 wait", drain_valid, 0);
        @(negedge clk); #1 check("R5 wait2", drain_valid, 0);
        inval_ack = 1'b1;
        @(negedge clk); inval_ack = 1'b0;

        j = 0; c = 0; held = 1'b0;
        st_valid = 1'b1; st_dep = 1'b0; st_addr = 8'h77; st_data = 16'h7777;
        #1;
        check("R10 ready", st_ready, 0);
        check("R10 spec", spec_wr_valid, 0);
        st_valid = 1'b0;
        while (j < n && c < 200) begin
            g = grant_of(gmode, c);
            drain_grant = g;
            fk = -1;
            if (late && (c % 2) == 0) begin
                for (int k = 0; k < n; k++)
                    if (fk < 0 && e_dep[k] && !e_rdy[k]) fk = k;
            end
            if (fk >= 0) begin
                fill_valid = 1'b1; fill_idx = PW'(base + fk); fill_data = e_data[fk];
            end else fill_valid = 1'b0;
            #1;
            v = drain_valid;
            check(e_rdy[j] ? "R6 valid" : "R7 stall", v, e_rdy[j]);
            if (v) begin
                check(held ? "R9 addr" : e_tag[j], drain_addr, e_addr[j]);
                check(held ? "R9 data" : e_tag[j], drain_data, e_data[j]);
            end
            @(posedge clk);
            held = v && !g;
            if (v && g) j++;
            if (fk >= 0) e_rdy[fk] = 1'b1;
            @(negedge clk);
            c++;
        end
        drain_grant = 1'b0; fill_valid = 1'b0;
        check("R6 count", j, n);
        #1 check("R10 empty", drain_valid, 0);
        @(negedge clk); #1;
        check("R10 idle", st_ready, 0);
        check("R10 noreq", inval_req, 0);
        base = base + n;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R11 ready", st_ready, 0);
        check("R11 inval", inval_req, 0);
        check("R11 drain", drain_valid, 0);
        check("R11 full", log_full, 0);
        rst_n = 1'b1;
        @(negedge clk); #1 check("R11 idle", st_ready, 0);
        for (int li = 0; li < 2; li++) begin
            for (int gm = 0; gm < 3; gm++) begin
                run(0, li[0], gm);
                run(1, li[0], gm);
                run(3, li[0], gm);
                run(5, li[0], gm);
                run(8, li[0], gm);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule